// File: doc/BRIEF.md
# Multi-Iteration Stencil Cone

This block takes one square window of a 2D frame and applies a fixed 4-neighbour update to it T times in a row. Each update is a weighted sum normalised by a shift. It returns the WO x WO window of points that the T-th iteration can compute exactly. That inner window needs an input window of WI = WO + 2T points on a side.

The iterations run as a stack of levels. Level k holds (WO + 2(T-k))^2 cells and is computed only from level k-1. Each value of a level is stored once in a register, and every cell of the next level that needs it reads that copy. Each input pixel carries a border flag. A flagged cell keeps its value through every level instead of being updated.

Pixels enter on a valid/ready stream in raster order. Results leave on a second valid/ready stream once the whole window has been loaded and all levels have been evaluated. A start pulse abandons the current window and clears all level storage.

Top module: `stencil_cone`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A window is exactly WI*WI pixels (WI = WO+2T), taken in raster order: index = row*WI + col, with row 0 first and column 0 first within a row. Each pixel carries its in_border flag. After the last pixel is accepted, in_ready is 0 until all results have been drained.
- R3: An unflagged cell at row r, column c of level k-1 becomes (N + S + E + W + 4*C) >> 3 at level k. N is row r-1, S is row r+1, W is column c-1 and E is column c+1. The sum is formed at full precision on unsigned 16-bit data, so it never wraps, and the shift truncates.
- R4: A cell whose input pixel was flagged keeps its value unchanged at every level. The flag stays with the frame position.
- R5: The output is the result of exactly T updates. Output cell (r, c) corresponds to input position (r+T, c+T). Level k has side WO+2(T-k).
- R6: No result is offered before the full window has arrived. The first out_valid appears exactly T clock cycles after the edge that accepts the last input pixel.
- R7: The WO*WO results leave in raster order. in_ready and out_valid are never both 1. The cycle after the last result is accepted, in_ready is 1 again.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_pix stay unchanged.
- R9: A start pulse clears all level storage and abandons any load or emit in progress. In the next cycle in_ready is 1, out_valid is 0 and loading restarts at index 0. A pixel offered in the start cycle is discarded.
- R10: Successive windows are independent; each result depends only on the pixels of its own window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears level storage and restarts the load |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_pix | input | 16 | Input pixel value |
| in_border | input | 1 | Cell is a frame-border cell |
| out_valid | output | 1 | Result pixel valid |
| out_ready | input | 1 | Consumer accepts a result |
| out_pix | output | 16 | Result pixel value |

## Verification
A full-scale window checks the sum width: a design that forms the sum in 16 bits wraps and returns a small value instead of 65535. An alternating 0/9 pattern shows whether the shift truncates, and a design that rounds gives a result one higher. Windows with flagged rows and columns, and one with every cell flagged, show whether border cells hold their value and stay at their frame position; a design that misplaces the flag smears the border into the interior. Start pulses in the middle of a load and in the middle of an emit, a fixed latency count and stalled outputs check the restart, the timing and the hold behaviour; a design that gets these wrong shifts the raster, emits early, or changes data while the output is stalled.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

    localparam int PIX_W = 16;
    localparam int ACC_W = PIX_W + 3;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic brd;
        pix_t val;
    } cell_t;

    typedef enum logic [1:0] {
        CS_LOAD,
        CS_CALC,
        CS_EMIT
    } cone_state_e;

    // Weighted 4-neighbour relaxation, full-precision sum, truncating shift.
    function automatic pix_t relax(pix_t n, pix_t s, pix_t e, pix_t w, pix_t c);
        logic [ACC_W-1:0] acc;
        acc = ACC_W'(n) + ACC_W'(s) + ACC_W'(e) + ACC_W'(w) + (ACC_W'(c) << 2);
        return acc[ACC_W-1:3];
    endfunction

endpackage

// File: rtl/cone_level.sv
module cone_level
    import stencil_pkg::*;
#(
    parameter int SIDE_IN   = 4,
    parameter int CELLS_MAX = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   en,
    input  cell_t [CELLS_MAX-1:0]  prev,
    output cell_t [CELLS_MAX-1:0]  cur
);

    localparam int SO = SIDE_IN - 2;
    localparam int NO = SO * SO;

    cell_t [NO-1:0] q;
    cell_t [NO-1:0] d;

    always_comb begin
        int ci;
        d = '0;
        for (int r = 0; r < SO; r++) begin
            for (int c = 0; c < SO; c++) begin
                ci = (r + 1) * SIDE_IN + c + 1;
                d[r*SO+c].brd = prev[ci].brd;
                if (prev[ci].brd)
                    d[r*SO+c].val = prev[ci].val;
                else
                    d[r*SO+c].val = relax(prev[ci-SIDE_IN].val, prev[ci+SIDE_IN].val,
                                          prev[ci+1].val, prev[ci-1].val, prev[ci].val);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (en)
            q <= d;
    end

    always_comb begin
        cur = '0;
        cur[NO-1:0] = q;
    end

endmodule

// File: rtl/cone_ctrl.sv
module cone_ctrl
    import stencil_pkg::*;
#(
    parameter int N_IN  = 64,
    parameter int N_OUT = 4,
    parameter int DEPTH = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       in_valid,
    input  logic                       out_ready,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic [$clog2(N_IN)-1:0]    in_idx,
    output logic [$clog2(N_OUT)-1:0]   out_idx,
    output logic [DEPTH-1:0]           lvl_en
);

    localparam int IW = $clog2(N_IN);
    localparam int OW = $clog2(N_OUT);
    localparam int SW = $clog2(DEPTH + 1);

    cone_state_e   state;
    logic [SW-1:0] step;

    assign in_ready  = (state == CS_LOAD);
    assign out_valid = (state == CS_EMIT);

    for (genvar k = 0; k < DEPTH; k++) begin : g_en
        assign lvl_en[k] = (state == CS_CALC) && (step == SW'(k + 1));
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            state   <= CS_LOAD;
            in_idx  <= '0;
            out_idx <= '0;
            step    <= '0;
        end else begin
            case (state)
                CS_LOAD: if (in_valid) begin
                    if (in_idx == IW'(N_IN - 1)) begin
                        in_idx <= '0;
                        step   <= SW'(1);
                        state  <= CS_CALC;
                    end else begin
                        in_idx <= in_idx + 1'b1;
                    end
                end
                CS_CALC: begin
                    if (step == SW'(DEPTH)) begin
                        step  <= '0;
                        state <= CS_EMIT;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                CS_EMIT: if (out_ready) begin
                    if (out_idx == OW'(N_OUT - 1)) begin
                        out_idx <= '0;
                        state   <= CS_LOAD;
                    end else begin
                        out_idx <= out_idx + 1'b1;
                    end
                end
                default: state <= CS_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/stencil_cone.sv
module stencil_cone
    import stencil_pkg::*;
#(
    parameter int WO = 2,
    parameter int T  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_border,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix
);

    localparam int WI    = WO + 2 * T;
    localparam int N_IN  = WI * WI;
    localparam int N_OUT = WO * WO;

    logic [$clog2(N_IN)-1:0]  in_idx;
    logic [$clog2(N_OUT)-1:0] out_idx;
    logic [T-1:0]             lvl_en;

    cell_t [N_IN-1:0] win_q;
    cell_t [N_IN-1:0] lvl [0:T];

    cone_ctrl #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .DEPTH (T)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .in_idx    (in_idx),
        .out_idx   (out_idx),
        .lvl_en    (lvl_en)
    );

    // Level 0: the loaded input window.
    always_ff @(posedge clk) begin
        if (rst || start)
            win_q <= '0;
        else if (in_valid && in_ready)
            win_q[in_idx] <= '{brd: in_border, val: in_pix};
    end

    assign lvl[0] = win_q;

    for (genvar k = 1; k <= T; k++) begin : g_lvl
        cone_level #(
            .SIDE_IN   (WI - 2 * (k - 1)),
            .CELLS_MAX (N_IN)
        ) u_level (
            .clk  (clk),
            .rst  (rst),
            .clr  (start),
            .en   (lvl_en[k-1]),
            .prev (lvl[k-1]),
            .cur  (lvl[k])
        );
    end

    assign out_pix = lvl[T][out_idx].val;

endmodule

// File: rtl/stencil_cone_chk.sv
module stencil_cone_chk
    import stencil_pkg::*;
#(
    parameter int N_IN  = 64,
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pix
);

    int acc_n;
    int out_n;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            acc_n <= 0;
            out_n <= 0;
        end else begin
            if (in_valid && in_ready)
                acc_n <= (acc_n == N_IN - 1) ? 0 : acc_n + 1;
            if (out_valid && out_ready)
                out_n <= (out_n == N_OUT - 1) ? 0 : out_n + 1;
        end
    end

    // R7: the two streams never run in the same cycle
    p_streams_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);

    // R8: stalled result holds
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_pix)));

    // R9: start returns to loading
    p_start_restart_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (in_ready && !out_valid));

    // R2: full window closes the input
    p_window_close_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !start && acc_n == N_IN - 1) |=> (!in_ready && !out_valid));

    // R7: last result reopens the input
    p_drain_reopen_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !start && out_n == N_OUT - 1) |=> in_ready);

endmodule

bind stencil_cone stencil_cone_chk #(
    .N_IN  ((WO + 2 * T) * (WO + 2 * T)),
    .N_OUT (WO * WO)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix)
);

// File: tb/stencil_cone_bench.sv
`timescale 1ns/1ps
module stencil_cone_bench;
    import stencil_pkg::*;

    localparam int WO    = 2;
    localparam int T     = 3;
    localparam int WI    = WO + 2 * T;
    localparam int N_IN  = WI * WI;
    localparam int N_OUT = WO * WO;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic        in_valid = 0;
    logic [15:0] in_pix = 0;
    logic        in_border = 0;
    logic        out_ready = 0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_pix;

    int          n_chk = 0;
    int          n_bad = 0;
    int          pix [N_IN];
    bit          flg [N_IN];
    int          expv [N_OUT];
    int unsigned seed = 32'h1234_5678;

    always #4 clk = ~clk;

    stencil_cone #(.WO(WO), .T(T)) u_stencil_cone (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .in_border (in_border),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:15]);
    endfunction

    // Reference: T updates over a shrinking window (R3, R4, R5).
    task automatic model();
        int cur [N_IN];
        bit cf  [N_IN];
        int nv  [N_IN];
        bit nf  [N_IN];
        int side;
        int ns;
        int ci;
        for (int i = 0; i < N_IN; i++) begin
            cur[i] = pix[i];
            cf[i]  = flg[i];
        end
        side = WI;
        for (int k = 1; k <= T; k++) begin
            ns = side - 2;
            for (int r = 0; r < ns; r++) begin
                for (int c = 0; c < ns; c++) begin
                    ci = (r + 1) * side + c + 1;
                    nf[r*ns+c] = cf[ci];
                    nv[r*ns+c] = cf[ci] ? cur[ci]
                               : ((cur[ci-side] + cur[ci+side] + cur[ci-1] + cur[ci+1] + 4 * cur[ci]) >> 3);
                end
            end
            for (int i = 0; i < ns * ns; i++) begin
                cur[i] = nv[i];
                cf[i]  = nf[i];
            end
            side = ns;
        end
        for (int o = 0; o < N_OUT; o++) expv[o] = cur[o];
    endtask

    task automatic load_window(input int upto);
        for (int i = 0; i < upto; i++) begin
            @(negedge clk);
            in_valid  = 1;
            in_pix    = 16'(pix[i]);
            in_border = flg[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic run_window(input string tag, input bit bp);
        int          lat;
        logic [15:0] held;
        model();
        load_window(N_IN);
        check(!in_ready, "R2 in_ready low after full window", int'(in_ready), 0);
        lat = 0;
        while (!out_valid && lat < 50) begin
            lat++;
            @(negedge clk);
        end
        check(lat == T, "R6 first result latency", lat, T);
        for (int o = 0; o < N_OUT; o++) begin
            if (bp) begin
                held      = out_pix;
                out_ready = 0;
                @(negedge clk);
                @(negedge clk);
                check(out_valid && out_pix == held, "R8 stalled result held", int'(out_pix), int'(held));
            end
            out_ready = 1;
            check(out_valid && !in_ready, "R7 result offered, input closed", int'(out_valid), 1);
            check(int'(out_pix) == expv[o], tag, int'(out_pix), expv[o]);
            @(posedge clk);
            @(negedge clk);
            out_ready = 0;
        end
        check(in_ready && !out_valid, "R7 input reopens after last result", int'(in_ready), 1);
    endtask

    task automatic t_reset();
        check(in_ready && !out_valid, "R1 reset state", int'(in_ready), 1);
    endtask

    task automatic t_uniform();
        for (int i = 0; i < N_IN; i++) begin pix[i] = 1000; flg[i] = 0; end
        run_window("R3 uniform window", 0);
        check(expv[0] == 1000, "R3 uniform fixed point", expv[0], 1000);
    endtask

    task automatic t_full_scale();
        for (int i = 0; i < N_IN; i++) begin pix[i] = 65535; flg[i] = 0; end
        run_window("R3 full-scale no wrap", 0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < N_IN; i++) begin pix[i] = (i * 977) % 65536; flg[i] = 0; end
        run_window("R5 ramp after T updates", 0);
    endtask

    task automatic t_trunc();
        for (int r = 0; r < WI; r++)
            for (int c = 0; c < WI; c++) begin
                pix[r*WI+c] = ((r + c) % 2 == 1) ? 9 : 0;
                flg[r*WI+c] = 0;
            end
        run_window("R3 truncating shift", 0);
    endtask

    task automatic t_border();
        for (int r = 0; r < WI; r++)
            for (int c = 0; c < WI; c++) begin
                pix[r*WI+c] = next_rand();
                flg[r*WI+c] = (r < 4) || (c == WI - 3);
            end
        run_window("R4 flagged rows and column", 1);
    endtask

    task automatic t_all_border();
        for (int i = 0; i < N_IN; i++) begin pix[i] = next_rand(); flg[i] = 1; end
        run_window("R4 all cells flagged", 0);
        check(expv[0] == pix[T*WI+T], "R5 output origin at input (T,T)", expv[0], pix[T*WI+T]);
    endtask

    task automatic t_start_midload();
        for (int i = 0; i < N_IN; i++) begin pix[i] = 50000; flg[i] = 0; end
        load_window(20);
        @(negedge clk);
        start    = 1;
        in_valid = 1;
        in_pix   = 16'd123;
        @(posedge clk);
        @(negedge clk);
        start    = 0;
        in_valid = 0;
        check(in_ready && !out_valid, "R9 start during load", int'(in_ready), 1);
        for (int i = 0; i < N_IN; i++) begin pix[i] = next_rand(); flg[i] = (i % 5 == 0); end
        run_window("R9 window after restart", 0);
    endtask

    task automatic t_start_midemit();
        for (int i = 0; i < N_IN; i++) begin pix[i] = next_rand(); flg[i] = 0; end
        load_window(N_IN);
        while (!out_valid) @(negedge clk);
        out_ready = 1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 0;
        start     = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        check(in_ready && !out_valid, "R9 start during emit", int'(out_valid), 0);
        for (int i = 0; i < N_IN; i++) begin pix[i] = next_rand(); flg[i] = 0; end
        run_window("R10 independent next window", 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_uniform();
        t_full_scale();
        t_ramp();
        t_trunc();
        t_border();
        t_all_border();
        t_start_midload();
        t_start_midemit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule